// File: doc/BRIEF.md
# Autopoll Target Scheduler

This block chooses the next device address to poll on a serial peripheral bus that has sixteen addresses. It watches three things: an autopoll enable mask, the most recent command byte that went out on the bus, and event pulses from the transaction sequencer. From these it builds a "Talk register 0" command for the chosen address. It also says whether that command must go in front of the requests already waiting, or be issued into an empty queue.

A service request means some device on the bus wants attention. In that case the scheduler moves on to the next enabled address above the device that was last addressed. This avoids polling the device that just answered. When the search passes the top of the address range, it wraps to the lowest enabled address. When a transaction completes and the queue has drained, the scheduler resumes round polling at the lowest enabled address. It does this only if the finished command was itself a Talk-register-0 poll of an enabled device. The same level output, `keep_polling`, reports that condition at all times. An explicit start pulse also begins polling at the lowest enabled address when the queue is empty.

The poll command leaves through a valid/ready output. The rules for back-pressure are:
- A command is registered and offered on the cycle after its trigger.
- The command is held unchanged while `poll_ready` is low.
- Any trigger that arrives during a stall is dropped. The sequencer is busy in that window and raises its events again later.
- Accepting one command and loading the next can happen in the same cycle.

Top module: `autopoll_sched`

## Requirements
- R1: Address 0 is never polled. Mask bit 0 is treated as zero, and no offered command carries address 0.
- R2: Every offered command has the address in bits 7:4 and the value 0xC in bits 3:0.
- R3: When `srq_evt` is high, the offered target is the lowest enabled address strictly above `last_cmd[7:4]`, with `poll_head` = 1.
- R4: When `srq_evt` is high and no enabled address lies above `last_cmd[7:4]`, the target wraps to the lowest enabled address.
- R5: If `srq_evt` arrives in the same cycle as `done_evt` or `start_evt`, the service-request poll wins.
- R6: `keep_polling` is high exactly when `last_cmd[3:0]` = 0xC and the mask bit for `last_cmd[7:4]` is set, with bit 0 counted as clear.
- R7: `done_evt` with `keep_polling` high and `queue_empty` high offers the lowest enabled address with `poll_head` = 0. With `queue_empty` low, nothing is offered.
- R8: `start_evt` with `queue_empty` high offers the lowest enabled address with `poll_head` = 0. With `queue_empty` low, nothing is offered.
- R9: When mask bits 15:1 are all zero, no trigger produces a command.
- R10: While `poll_valid` is high and `poll_ready` is low, `poll_cmd` and `poll_head` hold, and triggers in that window are dropped. Once the command is accepted, `poll_valid` falls unless a new trigger loads.
- R11: After reset, `poll_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poll_mask | input | 16 | Autopoll enable, one bit per address |
| last_cmd | input | 8 | Most recent command byte sent |
| srq_evt | input | 1 | Pulse: service request seen |
| done_evt | input | 1 | Pulse: transaction completed |
| start_evt | input | 1 | Pulse: begin autopolling |
| queue_empty | input | 1 | No request is waiting in the host queue |
| poll_ready | input | 1 | Consumer accepts the offered command |
| poll_valid | output | 1 | A poll command is offered |
| poll_cmd | output | 8 | Talk-register-0 command byte |
| poll_head | output | 1 | 1 = insert ahead of the queue, 0 = issue into the empty queue |
| keep_polling | output | 1 | Round polling should continue after this command |

## Verification
The assertions rely on one assumption. They treat a trigger as taking effect only on a cycle where the output register is free, which means `poll_valid` is low or `poll_ready` is high. They do not require the consumer to ever raise `poll_ready`. They also do not require the event pulses to be mutually exclusive. The stimulus drives every input at random, at the falling edge, including simultaneous events, stalls and masks with no usable bit. Expected values are computed with a cycle-level reference of the output register. That reference also covers the chosen priority among concurrent events.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
  // Which event produced the pending poll.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SRQ   = 2'd1,
    SRC_DONE  = 2'd2,
    SRC_START = 2'd3
  } poll_src_e;
endpackage

// File: rtl/ap_cmd_decode.sv
module ap_cmd_decode #(
  parameter int NADDR      = 16,
  parameter int CMD_W      = 8,
  parameter int TALK0_CODE = 12
) (
  input  logic [CMD_W-1:0]         cmd,
  input  logic [NADDR-1:0]         en_mask,
  output logic [$clog2(NADDR)-1:0] cmd_addr,
  output logic                     keep_polling
);
  localparam int AW  = $clog2(NADDR);
  localparam int OPW = CMD_W - AW;

  logic [OPW-1:0] op;
  logic           is_talk0;
  logic           addr_en;

  assign cmd_addr     = cmd[CMD_W-1 -: AW];
  assign op           = cmd[OPW-1:0];
  assign is_talk0     = (op == OPW'(TALK0_CODE));
  assign addr_en      = en_mask[cmd_addr];
  assign keep_polling = is_talk0 && addr_en;
endmodule

// File: rtl/ap_target_pick.sv
module ap_target_pick #(
  parameter int NADDR = 16
) (
  input  logic [NADDR-1:0]         en_mask,
  input  logic [$clog2(NADDR)-1:0] ref_addr,
  output logic                     any_en,
  output logic [$clog2(NADDR)-1:0] lowest,
  output logic [$clog2(NADDR)-1:0] next_tgt
);
  localparam int AW = $clog2(NADDR);

  logic [NADDR-1:0] above;
  logic [AW-1:0]    above_lo;
  logic             has_above;

  // Per-address qualifier: enabled and strictly above the reference.
  for (genvar g = 0; g < NADDR; g++) begin : g_above
    assign above[g] = en_mask[g] && (g > int'(ref_addr));
  end

  always_comb begin
    lowest = '0;
    for (int i = NADDR - 1; i >= 0; i--) begin
      if (en_mask[i]) lowest = AW'(i);
    end
  end

  always_comb begin
    above_lo = '0;
    for (int i = NADDR - 1; i >= 0; i--) begin
      if (above[i]) above_lo = AW'(i);
    end
  end

  assign any_en    = |en_mask;
  assign has_above = |above;
  assign next_tgt  = has_above ? above_lo : lowest;
endmodule

// File: rtl/ap_poll_issue.sv
module ap_poll_issue
  import autopoll_pkg::*;
#(
  parameter int NADDR      = 16,
  parameter int CMD_W      = 8,
  parameter int TALK0_CODE = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  poll_src_e                req_src,
  input  logic [$clog2(NADDR)-1:0] req_addr,
  input  logic                     req_head,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [CMD_W-1:0]         out_cmd,
  output logic                     out_head
);
  localparam int AW  = $clog2(NADDR);
  localparam int OPW = CMD_W - AW;

  logic slot_free;
  logic load;

  assign slot_free = !out_valid || out_ready;
  assign load      = slot_free && (req_src != SRC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cmd   <= '0;
      out_head  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_cmd   <= {req_addr, OPW'(TALK0_CODE)};
      out_head  <= req_head;
    end else if (slot_free) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
  import autopoll_pkg::*;
#(
  parameter int NADDR      = 16,
  parameter int CMD_W      = 8,
  parameter int TALK0_CODE = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NADDR-1:0] poll_mask,
  input  logic [CMD_W-1:0] last_cmd,
  input  logic             srq_evt,
  input  logic             done_evt,
  input  logic             start_evt,
  input  logic             queue_empty,
  input  logic             poll_ready,
  output logic             poll_valid,
  output logic [CMD_W-1:0] poll_cmd,
  output logic             poll_head,
  output logic             keep_polling
);
  localparam int AW = $clog2(NADDR);

  logic [NADDR-1:0] eff_mask;
  logic [AW-1:0]    cmd_addr;
  logic             any_en;
  logic [AW-1:0]    lowest;
  logic [AW-1:0]    next_tgt;
  poll_src_e        src;
  logic [AW-1:0]    tgt;
  logic             head;

  // Address 0 is never a poll target.
  assign eff_mask = {poll_mask[NADDR-1:1], 1'b0};

  ap_cmd_decode #(
    .NADDR(NADDR), .CMD_W(CMD_W), .TALK0_CODE(TALK0_CODE)
  ) u_dec (
    .cmd          (last_cmd),
    .en_mask      (eff_mask),
    .cmd_addr     (cmd_addr),
    .keep_polling (keep_polling)
  );

  ap_target_pick #(.NADDR(NADDR)) u_pick (
    .en_mask  (eff_mask),
    .ref_addr (cmd_addr),
    .any_en   (any_en),
    .lowest   (lowest),
    .next_tgt (next_tgt)
  );

  // Event priority: service request, then completion, then start.
  always_comb begin
    src  = SRC_NONE;
    tgt  = lowest;
    head = 1'b0;
    if (srq_evt && any_en) begin
      src  = SRC_SRQ;
      tgt  = next_tgt;
      head = 1'b1;
    end else if (done_evt && keep_polling && queue_empty) begin
      src = SRC_DONE;
    end else if (start_evt && queue_empty && any_en) begin
      src = SRC_START;
    end
  end

  ap_poll_issue #(
    .NADDR(NADDR), .CMD_W(CMD_W), .TALK0_CODE(TALK0_CODE)
  ) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_src   (src),
    .req_addr  (tgt),
    .req_head  (head),
    .out_ready (poll_ready),
    .out_valid (poll_valid),
    .out_cmd   (poll_cmd),
    .out_head  (poll_head)
  );
endmodule

// File: rtl/ap_sched_checker.sv
module ap_sched_checker #(
  parameter int NADDR      = 16,
  parameter int CMD_W      = 8,
  parameter int TALK0_CODE = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NADDR-1:0] poll_mask,
  input logic             srq_evt,
  input logic             queue_empty,
  input logic             poll_ready,
  input logic             poll_valid,
  input logic [CMD_W-1:0] poll_cmd,
  input logic             poll_head
);
  localparam int AW  = $clog2(NADDR);
  localparam int OPW = CMD_W - AW;

  logic free;
  assign free = !poll_valid || poll_ready;

  assert_no_addr0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid |-> (poll_cmd[CMD_W-1 -: AW] != '0));

  assert_talk0_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid |-> (poll_cmd[OPW-1:0] == OPW'(TALK0_CODE)));

  assert_srq_at_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (free && srq_evt && (poll_mask[NADDR-1:1] != '0)) |=> (poll_valid && poll_head));

  assert_busy_queue_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !srq_evt && !queue_empty) |=> !poll_valid);

  assert_empty_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (free && (poll_mask[NADDR-1:1] == '0)) |=> !poll_valid);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_valid && !poll_ready) |=> (poll_valid && $stable(poll_cmd) && $stable(poll_head)));
endmodule

bind autopoll_sched ap_sched_checker #(
  .NADDR(NADDR), .CMD_W(CMD_W), .TALK0_CODE(TALK0_CODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .poll_mask   (poll_mask),
  .srq_evt     (srq_evt),
  .queue_empty (queue_empty),
  .poll_ready  (poll_ready),
  .poll_valid  (poll_valid),
  .poll_cmd    (poll_cmd),
  .poll_head   (poll_head)
);

// File: tb/autopoll_sched_test.sv
module autopoll_sched_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] poll_mask = '0;
  logic [7:0]  last_cmd = '0;
  logic        srq_evt = 1'b0, done_evt = 1'b0, start_evt = 1'b0;
  logic        queue_empty = 1'b0, poll_ready = 1'b0;
  logic        poll_valid, poll_head, keep_polling;
  logic [7:0]  poll_cmd;

  int checks = 0;
  int errors = 0;

  // Reference state of the offered command.
  logic       m_valid = 1'b0;
  logic [7:0] m_cmd = '0;
  logic       m_head = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autopoll_sched uut (
    .clk(clk), .rst_n(rst_n), .poll_mask(poll_mask), .last_cmd(last_cmd),
    .srq_evt(srq_evt), .done_evt(done_evt), .start_evt(start_evt),
    .queue_empty(queue_empty), .poll_ready(poll_ready),
    .poll_valid(poll_valid), .poll_cmd(poll_cmd), .poll_head(poll_head),
    .keep_polling(keep_polling)
  );

  function automatic logic [3:0] f_lowest(logic [15:0] m);
    logic [3:0] r = '0;
    for (int i = 15; i >= 1; i--) if (m[i]) r = 4'(i);
    return r;
  endfunction

  function automatic logic [3:0] f_after(logic [15:0] m, logic [3:0] a);
    for (int i = 1; i < 16; i++) if (m[i] && i > int'(a)) return 4'(i);
    return f_lowest(m);
  endfunction

  function automatic logic f_keep(logic [15:0] m, logic [7:0] c);
    return (c[3:0] == 4'hC) && (c[7:4] != 4'd0) && m[c[7:4]];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(logic [15:0] m, logic [7:0] c, logic s, logic d,
                      logic st, logic qe, logic rdy, string tag);
    logic any, trig, hd;
    logic [3:0] a;
    poll_mask = m; last_cmd = c; srq_evt = s; done_evt = d;
    start_evt = st; queue_empty = qe; poll_ready = rdy;
    #1;
    check("R6 keep_polling", 32'(keep_polling), 32'(f_keep(m, c)));
    any = (m[15:1] != '0);
    trig = 1'b0; hd = 1'b0; a = f_lowest(m);
    if (s && any) begin trig = 1'b1; hd = 1'b1; a = f_after(m, c[7:4]); end
    else if (d && f_keep(m, c) && qe) trig = 1'b1;
    else if (st && qe && any) trig = 1'b1;
    if (!m_valid || rdy) begin
      m_valid = trig;
      if (trig) begin m_cmd = {a, 4'hC}; m_head = hd; end
    end
    @(posedge clk); #1;
    check({tag, " valid"}, 32'(poll_valid), 32'(m_valid));
    if (m_valid) begin
      check({tag, " cmd"}, 32'(poll_cmd), 32'(m_cmd));
      check({tag, " head"}, 32'(poll_head), 32'(m_head));
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0011));
    repeat (3) @(negedge clk);
    check("R11 reset valid", 32'(poll_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R9: only bit 0 set, nothing may be produced
    step(16'h0001, 8'h0C, 1, 1, 1, 1, 1, "R1 bit0 only");
    step(16'h0000, 8'h2C, 1, 0, 1, 1, 1, "R9 zero mask");
    // R8: start picks lowest enabled (2)
    step(16'h00A5, 8'h00, 0, 0, 1, 1, 1, "R8 start empty");
    step(16'h00A5, 8'h00, 0, 0, 1, 0, 1, "R8 start busy");
    // R3: above 5 is 7; above 3 (disabled) is 5
    step(16'h00A5, 8'h5C, 1, 0, 0, 0, 1, "R3 srq next");
    step(16'h00A5, 8'h31, 1, 0, 0, 0, 1, "R3 srq from disabled");
    // R4: above 7 wraps to 2
    step(16'h00A5, 8'h7C, 1, 0, 0, 0, 1, "R4 srq wrap");
    step(16'h8000, 8'hFC, 1, 0, 0, 1, 1, "R4 srq single");
    // R5: srq beats done and start
    step(16'h00A5, 8'h2C, 1, 1, 1, 1, 1, "R5 priority");
    // R6/R7
    step(16'h00A5, 8'h5C, 0, 1, 0, 1, 1, "R7 done resumes");
    step(16'h00A5, 8'h5C, 0, 1, 0, 0, 1, "R7 done busy");
    step(16'h00A5, 8'h5D, 0, 1, 0, 1, 1, "R7 not talk0");
    step(16'h00A5, 8'h4C, 0, 1, 0, 1, 1, "R7 addr disabled");
    step(16'h00A5, 8'h0C, 0, 1, 0, 1, 1, "R6 addr0");
    // R10: stall holds and drops triggers
    step(16'h00A5, 8'h00, 0, 0, 1, 1, 0, "R10 load");
    step(16'h00A5, 8'h5C, 1, 0, 0, 1, 0, "R10 stall srq");
    step(16'h00A5, 8'h00, 0, 0, 0, 1, 0, "R10 stall idle");
    step(16'h00A5, 8'h00, 0, 0, 0, 1, 1, "R10 accept");
    step(16'h00A5, 8'h00, 0, 0, 1, 1, 0, "R10 reload");
    step(16'h00A5, 8'h7C, 1, 0, 0, 0, 1, "R10 back-to-back");

    for (int n = 0; n < 600; n++) begin
      logic [15:0] m;
      logic [7:0]  c;
      case ($urandom % 5)
        0: m = 16'h0;
        1: m = 16'h0001 | (16'h1 << ($urandom % 16));
        default: m = 16'($urandom);
      endcase
      c = 8'($urandom);
      if ($urandom % 2 == 0) c[3:0] = 4'hC;
      step(m, c, ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
           ($urandom % 3) != 0, ($urandom % 4) != 0, "R3 R7 R8 R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule